// File: doc/BRIEF.md
# Correlated Multiple Sampling Sequencer

This block controls one column of a low-noise image sensor readout. The readout uses a switched-capacitor integrator that adds up many samples of the pixel output. For each pixel row the block runs two bursts of M sample/transfer cycles. The first burst samples the pixel's reset level and the second samples its photo-signal level. Before each burst the integrator is cleared. After each burst the integrator output is held and sent to the column ADC. The two resulting codes are stored, and the block reports their signed difference. Taking this difference digitally removes pixel offset and column offset.

A single `start` strobe begins a row. The sample count M and the gap count MG are latched at that strobe. The timing is built from a four-clock sample period: sample phase, idle clock, transfer phase, idle clock. The spacing between the first reset-level sample and the first signal-level sample is measured in these periods. The integrator, the ADC and the pixel are outside the block.

The controller moves through these states:
- IDLE, then INT_RST when `start` is seen.
- INT_RST, then SAMP on the reset level, or TX on the signal level.
- TX, then GAP.
- GAP, then SAMP when the spacing target is reached.
- SAMP, then IDLE_A, then XFER, then IDLE_B.
- IDLE_B, then SAMP for another cycle, or HOLD after cycle M.
- HOLD, then CONV, then WAIT.
- WAIT, on `adc_done`: INT_RST (signal level) after the reset-level code, or DONE after the signal-level code.
- DONE, then IDLE.

Top module: `cms_sequencer`

## Requirements
- R1: While `rst_n` is low, and after it is released with no `start`, every control output is 0. `busy` and `diff_valid` are also 0.
- R2: One sample period is four clocks: `samp` high for one clock, one idle clock, `xfer` high for one clock, one idle clock. `samp` and `xfer` are never high in the same clock. Within a burst, consecutive `samp` pulses are 4 clocks apart, and each `xfer` pulse comes 2 clocks after its `samp`.
- R3: `samp_d` is high whenever `samp` is high and also in the clock after; otherwise it is low. `xfer_d` follows `xfer` in the same way.
- R4: Each burst holds exactly M sample periods. An M of 0 is treated as 1.
- R5: Each burst is preceded by a one-clock `int_rst` pulse. For the reset level this pulse is in the clock just before the first `samp`. `pix_rst` is high in that same clock, and only for the reset level.
- R6: `sh_strobe` pulses 2 clocks after the last `xfer` of a burst, and `adc_start` pulses in the next clock. `adc_done` is taken only while the block waits for a conversion; at any other time it has no effect on the stored codes.
- R7: After the reset-level code arrives, the block gives a one-clock `int_rst`, then one clock of `tx_gate`, and only then starts the signal-level burst. There is exactly one `tx_gate` pulse per row.
- R8: Let t0 be the clock of the first reset-level `samp` and L the number of clocks from `adc_start` to `adc_done`. The first signal-level `samp` comes at t0 + max(4·(M+MG−1), 4·M+5+L). An MG of 0 is treated as 1.
- R9: `diff` equals the signal code minus the reset code, as a signed value one bit wider than the ADC code. `diff_valid` pulses for exactly one clock per row.
- R10: `busy` rises in the clock after an accepted `start` and falls in the clock after `diff_valid`. A `start` while `busy` is high is ignored. M and MG are latched at the accepted `start`, and later changes to the inputs have no effect on that row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a row sequence |
| m_cnt | input | M_W | Samples per level (0 means 1) |
| mg_cnt | input | G_W | Gap count in sample periods (0 means 1) |
| adc_code | input | CODE_W | Conversion result |
| adc_done | input | 1 | Conversion finished, code valid |
| int_rst | output | 1 | Integrator feedback capacitor reset phase |
| samp | output | 1 | Sampling phase |
| samp_d | output | 1 | Delayed sampling phase |
| xfer | output | 1 | Charge transfer phase |
| xfer_d | output | 1 | Delayed transfer phase |
| pix_rst | output | 1 | Pixel floating-diffusion reset |
| tx_gate | output | 1 | Pixel transfer gate pulse |
| sh_strobe | output | 1 | Sample-and-hold capture |
| adc_start | output | 1 | Conversion start |
| busy | output | 1 | Sequence in progress |
| diff | output | CODE_W+1 | Signed signal-minus-reset code |
| diff_valid | output | 1 | One-clock qualifier of `diff` |

## Verification
The hardest case to reach from the ports is the late signal burst. Here the conversion of the reset level is still running when the MG-based spacing target passes, so the start time comes from the second term of the spacing rule rather than the first. The bench reaches it with an ADC stub whose latency can be set per row: a 40-clock latency combined with a small MG pushes the signal burst past its nominal slot. A second row-level corner is a stray `adc_done` carrying an all-ones code in the middle of a burst. It is paired with a second `start` that carries a different M, so the ignored-input rules are checked against the final difference code.

// File: rtl/cms_pkg.sv
package cms_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_INT_RST,
        ST_TX,
        ST_GAP,
        ST_SAMP,
        ST_IDLE_A,
        ST_XFER,
        ST_IDLE_B,
        ST_HOLD,
        ST_CONV,
        ST_WAIT,
        ST_DONE
    } seq_state_t;

    typedef enum logic {
        LVL_RESET  = 1'b0,
        LVL_SIGNAL = 1'b1
    } level_t;

endpackage

// File: rtl/cms_phase_delay.sv
module cms_phase_delay #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ph,
    output logic [N-1:0] ph_d
);

    for (genvar i = 0; i < N; i++) begin : g_lane
        logic held_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                held_q <= 1'b0;
            end else begin
                held_q <= ph[i];
            end
        end

        // stretched copy: rises with the phase, drops one clock after it
        assign ph_d[i] = ph[i] | held_q;
    end

endmodule

// File: rtl/cms_code_store.sv
module cms_code_store
    import cms_pkg::*;
#(
    parameter int CODE_W = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cap_en,
    input  level_t                   cap_sel,
    input  logic [CODE_W-1:0]        code,
    output logic signed [CODE_W:0]   diff
);

    logic [CODE_W-1:0] base_code_q;
    logic [CODE_W-1:0] sig_code_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_code_q <= '0;
            sig_code_q  <= '0;
        end else if (cap_en) begin
            if (cap_sel == LVL_RESET) begin
                base_code_q <= code;
            end else begin
                sig_code_q  <= code;
            end
        end
    end

    assign diff = $signed({1'b0, sig_code_q}) - $signed({1'b0, base_code_q});

endmodule

// File: rtl/cms_fsm.sv
module cms_fsm
    import cms_pkg::*;
#(
    parameter int M_W = 8,
    parameter int G_W = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [M_W-1:0] m_cnt,
    input  logic [G_W-1:0] mg_cnt,
    input  logic           adc_done,
    output logic           int_rst,
    output logic           samp,
    output logic           xfer,
    output logic           pix_rst,
    output logic           tx_gate,
    output logic           sh_strobe,
    output logic           adc_start,
    output logic           busy,
    output logic           diff_valid,
    output logic           cap_en,
    output level_t         cap_sel
);

    localparam int SUM_W = ((M_W > G_W) ? M_W : G_W) + 1;
    localparam int EL_W  = SUM_W + 2;

    seq_state_t      state, nxt;
    level_t          lvl;
    logic [M_W-1:0]  m_lat;
    logic [G_W-1:0]  g_lat;
    logic [M_W-1:0]  burst_cnt;
    logic [EL_W-1:0] elapsed;
    logic [SUM_W-1:0] span;
    logic [EL_W-1:0] target;
    logic            last_cycle;
    logic            gap_reached;

    assign span        = SUM_W'(m_lat) + SUM_W'(g_lat) - SUM_W'(1);
    assign target      = {span, 2'b00};
    assign last_cycle  = (burst_cnt == (m_lat - M_W'(1)));
    assign gap_reached = (elapsed >= (target - EL_W'(1)));

    // state register and sequence counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            lvl       <= LVL_RESET;
            m_lat     <= M_W'(1);
            g_lat     <= G_W'(1);
            burst_cnt <= '0;
            elapsed   <= '0;
        end else begin
            state <= nxt;
            if (state == ST_INT_RST && lvl == LVL_RESET) begin
                elapsed <= '0;
            end else if (elapsed != '1) begin
                elapsed <= elapsed + EL_W'(1);
            end
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        m_lat     <= (m_cnt  == '0) ? M_W'(1) : m_cnt;
                        g_lat     <= (mg_cnt == '0) ? G_W'(1) : mg_cnt;
                        lvl       <= LVL_RESET;
                        burst_cnt <= '0;
                    end
                end
                ST_IDLE_B: begin
                    burst_cnt <= last_cycle ? '0 : burst_cnt + M_W'(1);
                end
                ST_WAIT: begin
                    if (adc_done && lvl == LVL_RESET) begin
                        lvl <= LVL_SIGNAL;
                    end
                end
                default: ;
            endcase
        end
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (start) nxt = ST_INT_RST;
            ST_INT_RST: nxt = (lvl == LVL_RESET) ? ST_SAMP : ST_TX;
            ST_TX:      nxt = ST_GAP;
            ST_GAP:     if (gap_reached) nxt = ST_SAMP;
            ST_SAMP:    nxt = ST_IDLE_A;
            ST_IDLE_A:  nxt = ST_XFER;
            ST_XFER:    nxt = ST_IDLE_B;
            ST_IDLE_B:  nxt = last_cycle ? ST_HOLD : ST_SAMP;
            ST_HOLD:    nxt = ST_CONV;
            ST_CONV:    nxt = ST_WAIT;
            ST_WAIT: begin
                if (adc_done) nxt = (lvl == LVL_RESET) ? ST_INT_RST : ST_DONE;
            end
            ST_DONE:    nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        int_rst    = 1'b0;
        samp       = 1'b0;
        xfer       = 1'b0;
        pix_rst    = 1'b0;
        tx_gate    = 1'b0;
        sh_strobe  = 1'b0;
        adc_start  = 1'b0;
        diff_valid = 1'b0;
        cap_en     = 1'b0;
        cap_sel    = lvl;
        busy       = (state != ST_IDLE);
        unique case (state)
            ST_INT_RST: begin
                int_rst = 1'b1;
                pix_rst = (lvl == LVL_RESET);
            end
            ST_TX:   tx_gate    = 1'b1;
            ST_SAMP: samp       = 1'b1;
            ST_XFER: xfer       = 1'b1;
            ST_HOLD: sh_strobe  = 1'b1;
            ST_CONV: adc_start  = 1'b1;
            ST_WAIT: cap_en     = adc_done;
            ST_DONE: diff_valid = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/cms_sequencer.sv
module cms_sequencer
    import cms_pkg::*;
#(
    parameter int M_W    = 8,
    parameter int G_W    = 9,
    parameter int CODE_W = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [M_W-1:0]          m_cnt,
    input  logic [G_W-1:0]          mg_cnt,
    input  logic [CODE_W-1:0]       adc_code,
    input  logic                    adc_done,
    output logic                    int_rst,
    output logic                    samp,
    output logic                    samp_d,
    output logic                    xfer,
    output logic                    xfer_d,
    output logic                    pix_rst,
    output logic                    tx_gate,
    output logic                    sh_strobe,
    output logic                    adc_start,
    output logic                    busy,
    output logic signed [CODE_W:0]  diff,
    output logic                    diff_valid
);

    logic   cap_en;
    level_t cap_sel;
    logic [1:0] main_ph;
    logic [1:0] late_ph;

    cms_fsm #(.M_W(M_W), .G_W(G_W)) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .m_cnt      (m_cnt),
        .mg_cnt     (mg_cnt),
        .adc_done   (adc_done),
        .int_rst    (int_rst),
        .samp       (samp),
        .xfer       (xfer),
        .pix_rst    (pix_rst),
        .tx_gate    (tx_gate),
        .sh_strobe  (sh_strobe),
        .adc_start  (adc_start),
        .busy       (busy),
        .diff_valid (diff_valid),
        .cap_en     (cap_en),
        .cap_sel    (cap_sel)
    );

    assign main_ph = {xfer, samp};

    cms_phase_delay #(.N(2)) i_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .ph    (main_ph),
        .ph_d  (late_ph)
    );

    assign samp_d = late_ph[0];
    assign xfer_d = late_ph[1];

    cms_code_store #(.CODE_W(CODE_W)) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_en  (cap_en),
        .cap_sel (cap_sel),
        .code    (adc_code),
        .diff    (diff)
    );

endmodule

// File: rtl/cms_sequencer_chk.sv
module cms_sequencer_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic int_rst,
    input logic samp,
    input logic samp_d,
    input logic xfer,
    input logic xfer_d,
    input logic pix_rst,
    input logic tx_gate,
    input logic sh_strobe,
    input logic adc_start,
    input logic diff_valid
);

    // R2
    no_phase_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(samp && xfer));

    // R3
    samp_d_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(samp) |-> samp_d);

    // R3
    samp_d_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_d && !samp) |-> $past(samp));

    // R3
    xfer_d_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_d && !xfer) |-> $past(xfer));

    // R5
    pix_rst_with_int_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_rst |-> int_rst);

    // R6
    adc_after_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> $past(sh_strobe));

    // R6
    hold_after_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sh_strobe |-> $past(xfer, 2));

    // R7
    tx_after_int_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_gate |-> $past(int_rst));

    // R9
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        diff_valid |=> !diff_valid);

    // R10
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        diff_valid |=> !busy);

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !diff_valid) |=> busy);

    // R10
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            idle_in_reset_chk: assert (!busy && !diff_valid);
        end
    end

endmodule

bind cms_sequencer cms_sequencer_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .int_rst    (int_rst),
    .samp       (samp),
    .samp_d     (samp_d),
    .xfer       (xfer),
    .xfer_d     (xfer_d),
    .pix_rst    (pix_rst),
    .tx_gate    (tx_gate),
    .sh_strobe  (sh_strobe),
    .adc_start  (adc_start),
    .diff_valid (diff_valid)
);

// File: tb/test_cms_sequencer.sv
`timescale 1ns/1ps
module test_cms_sequencer;

    localparam int M_W    = 8;
    localparam int G_W    = 9;
    localparam int CODE_W = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [M_W-1:0] m_in = '0;
    logic [G_W-1:0] g_in = '0;
    logic [CODE_W-1:0] adc_code = '0;
    logic adc_done = 1'b0;
    logic int_rst, samp, samp_d, xfer, xfer_d, pix_rst, tx_gate;
    logic sh_strobe, adc_start, busy, diff_valid;
    logic signed [CODE_W:0] diff;

    always #4 clk = ~clk;

    cms_sequencer #(.M_W(M_W), .G_W(G_W), .CODE_W(CODE_W)) i_cms_sequencer (
        .clk(clk), .rst_n(rst_n), .start(start), .m_cnt(m_in), .mg_cnt(g_in),
        .adc_code(adc_code), .adc_done(adc_done), .int_rst(int_rst),
        .samp(samp), .samp_d(samp_d), .xfer(xfer), .xfer_d(xfer_d),
        .pix_rst(pix_rst), .tx_gate(tx_gate), .sh_strobe(sh_strobe),
        .adc_start(adc_start), .busy(busy), .diff(diff), .diff_valid(diff_valid)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // behavioural pixel, integrator and ADC
    int cyc = 0;
    int integ = 0;
    int held = 0;
    bit charged = 0;
    int vr = 0;
    int vs = 0;
    int adc_lat = 3;
    int adc_cnt = 0;
    int glitch_cyc = -1;

    // monitor records
    int q_samp[$], q_xfer[$], q_irst[$], q_prst[$], q_tx[$], q_sh[$], q_ast[$];
    int nvalid = 0;
    int diff_seen = 0;
    int ovl_err = 0;
    int dly_err = 0;
    bit prev_samp = 0;
    bit prev_xfer = 0;

    always @(negedge clk) begin
        cyc++;
        adc_done = 1'b0;
        if (int_rst) integ = 0;
        if (pix_rst) charged = 0;
        if (tx_gate) charged = 1;
        if (xfer)    integ += charged ? vs : vr;
        if (sh_strobe) held = integ;
        if (adc_cnt > 0) begin
            adc_cnt--;
            if (adc_cnt == 0) begin
                adc_done = 1'b1;
                adc_code = CODE_W'(held);
            end
        end
        if (adc_start) adc_cnt = adc_lat;
        if (cyc == glitch_cyc) begin
            adc_done = 1'b1;
            adc_code = '1;
        end
        if (samp)      q_samp.push_back(cyc);
        if (xfer)      q_xfer.push_back(cyc);
        if (int_rst)   q_irst.push_back(cyc);
        if (pix_rst)   q_prst.push_back(cyc);
        if (tx_gate)   q_tx.push_back(cyc);
        if (sh_strobe) q_sh.push_back(cyc);
        if (adc_start) q_ast.push_back(cyc);
        if (diff_valid) begin
            nvalid++;
            diff_seen = int'(diff);
        end
        if (samp && xfer) ovl_err++;
        if (samp_d !== (samp | prev_samp)) dly_err++;
        if (xfer_d !== (xfer | prev_xfer)) dly_err++;
        prev_samp = samp;
        prev_xfer = xfer;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_row(input int m, input int g, input int r_lvl, input int s_lvl,
                           input int lat, input bit disturb);
        int me, ge, t0, t1, exp_gap, k;
        me = (m == 0) ? 1 : m;
        ge = (g == 0) ? 1 : g;
        vr = r_lvl;
        vs = s_lvl;
        adc_lat = lat;
        q_samp.delete(); q_xfer.delete(); q_irst.delete(); q_prst.delete();
        q_tx.delete(); q_sh.delete(); q_ast.delete();
        nvalid = 0; ovl_err = 0; dly_err = 0;
        @(negedge clk);
        m_in = M_W'(m);
        g_in = G_W'(g);
        start = 1'b1;
        glitch_cyc = disturb ? cyc + 12 : -1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R10 busy after start", busy, 1);
        k = 0;
        while (nvalid == 0 && k < 20000) begin
            @(negedge clk);
            k++;
            if (disturb && k == 20) begin
                start = 1'b1;
                m_in = M_W'(64);
                g_in = G_W'(3);
            end
            if (disturb && k == 21) start = 1'b0;
        end
        @(negedge clk);
        chk(busy === 1'b0, "R10 busy low after valid", busy, 0);
        repeat (3) @(negedge clk);
        chk(nvalid == 1, "R9 single valid pulse", nvalid, 1);
        chk(diff_seen == me * (s_lvl - r_lvl), "R9 difference code", diff_seen, me * (s_lvl - r_lvl));
        chk(ovl_err == 0, "R2 samp/xfer overlap", ovl_err, 0);
        chk(dly_err == 0, "R3 delayed phase shape", dly_err, 0);
        chk(q_samp.size() == 2 * me, "R4 samp count", q_samp.size(), 2 * me);
        chk(q_xfer.size() == 2 * me, "R4 xfer count", q_xfer.size(), 2 * me);
        chk(q_tx.size() == 1, "R7 tx pulse count", q_tx.size(), 1);
        chk(q_prst.size() == 1, "R5 pixel reset count", q_prst.size(), 1);
        chk(q_irst.size() == 2, "R5 integrator reset count", q_irst.size(), 2);
        chk(q_sh.size() == 2 && q_ast.size() == 2, "R6 hold/convert count", q_sh.size() + q_ast.size(), 4);
        if (q_samp.size() == 2 * me && q_xfer.size() == 2 * me && q_irst.size() == 2 &&
            q_prst.size() == 1 && q_tx.size() == 1 && q_sh.size() == 2 && q_ast.size() == 2) begin
            int bad;
            t0 = q_samp[0];
            t1 = q_samp[me];
            bad = 0;
            for (int i = 0; i < me; i++) begin
                if (q_samp[i] != t0 + 4 * i || q_samp[me + i] != t1 + 4 * i) bad++;
                if (q_xfer[i] != q_samp[i] + 2 || q_xfer[me + i] != q_samp[me + i] + 2) bad++;
            end
            chk(bad == 0, "R2 sample period layout", bad, 0);
            exp_gap = 4 * (me + ge - 1);
            if (4 * me + 5 + lat > exp_gap) exp_gap = 4 * me + 5 + lat;
            chk(t1 - t0 == exp_gap, "R8 burst spacing", t1 - t0, exp_gap);
            chk(q_irst[0] == t0 - 1 && q_prst[0] == t0 - 1, "R5 reset before first burst", q_prst[0], t0 - 1);
            chk(q_irst[1] > q_xfer[me - 1] && q_tx[0] == q_irst[1] + 1 && q_tx[0] < t1,
                "R7 reset then tx before signal burst", q_tx[0], q_irst[1] + 1);
            chk(q_sh[0] == q_xfer[me - 1] + 2 && q_ast[0] == q_sh[0] + 1, "R6 hold after reset burst", q_ast[0], q_xfer[me - 1] + 3);
            chk(q_sh[1] == q_xfer[2 * me - 1] + 2 && q_ast[1] == q_sh[1] + 1, "R6 hold after signal burst", q_ast[1], q_xfer[2 * me - 1] + 3);
        end
        glitch_cyc = -1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk({int_rst, samp, samp_d, xfer, xfer_d, pix_rst, tx_gate, sh_strobe, adc_start, busy, diff_valid} == '0,
            "R1 outputs in reset", busy, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk({int_rst, samp, samp_d, xfer, xfer_d, pix_rst, tx_gate, sh_strobe, adc_start, busy, diff_valid} == '0,
            "R1 outputs idle after reset", busy, 0);
        run_row(4, 16, 3, 9, 3, 0);      // R8 nominal spacing
        run_row(128, 268, 2, 7, 3, 0);   // R4 large M, large MG
        run_row(0, 0, 10, 4, 3, 0);      // R4 R8 zero treated as one, negative diff
        run_row(2, 2, 5, 6, 40, 0);      // R8 late signal burst behind slow ADC
        run_row(8, 16, 4, 11, 3, 1);     // R10 R6 second start and stray adc_done ignored
        run_row(64, 300, 1, 15, 3, 0);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule